// File: doc/BRIEF.md
# Prefix Immediate Accumulator

This decode-stage unit watches a stream of 16-bit instruction words. A word whose top nibble is the prefix opcode has no effect of its own. Its low 12 bits are shifted into a hidden 32-bit constant register instead. The first ordinary instruction that follows one or more prefixes takes that constant as an immediate, and the immediate replaces the instruction's B source register. Once the constant has been used, the register is cleared.

Because prefix words change the meaning of the word that follows them, the instruction stream is context-sensitive. For that reason the unit also records the address of the first prefix in each run. After every accepted word, a registered restart address gives the PC that an interrupt taken at that word must return to. If the word was inside a prefix run, or was the word that ends one, this is the start of the run. Otherwise it is the word's own PC. An interrupt request is accepted only together with a valid word. The interrupted word is turned into a no-op, and any pending constant is discarded. The interrupt dispatch itself lies outside this unit.

Top module: `pfx_imm_acc`

## Requirements
- R1: A valid word whose bits [15:12] equal 4'hF is a prefix. The unit raises `nop_out` and keeps `use_imm` low for it in the same cycle. Any other opcode value, including 4'hE, is not a prefix.
- R2: When a prefix-consuming word is presented, `imm_out` equals the low 32 bits of the concatenated 12-bit payloads of the run, zero-extended, with the earliest payload most significant.
- R3: A valid, non-interrupted, non-prefix word that follows a pending run drives `use_imm` high in the same cycle. The constant is then cleared, so the next ordinary word has `use_imm` low.
- R4: A non-prefix word with no pending run gives `use_imm` = 0, `imm_out` = 0 and `nop_out` = 0.
- R5: One clock after each valid word, `restart_pc` holds the PC of the first prefix of the run that was pending before that word, or that word's own PC when no run was pending.
- R6: Second and later prefixes in a run leave `restart_pc` at the address of the first prefix.
- R7: When `irq_req` is high together with `in_valid`, the word is squashed (`nop_out` = 1, `use_imm` = 0) and the pending constant is dropped. The restart address from R5 still applies.
- R8: Cycles with `in_valid` low drive all outputs except `restart_pc` to zero and change no state, even when `irq_req` is high.
- R9: After reset, no run is pending and `restart_pc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word valid this cycle |
| in_insn | input | 16 | Instruction word |
| in_pc | input | 32 | Address of the instruction word |
| irq_req | input | 1 | Interrupt request; accepted only together with in_valid |
| use_imm | output | 1 | Select the immediate in place of register B |
| imm_out | output | 32 | Accumulated immediate; zero when use_imm is low |
| nop_out | output | 1 | Word retires as a no-op (prefix or squashed) |
| restart_pc | output | 32 | Registered return address for the last accepted word |

## Verification
The assertions assume that the inputs are known (not X) after reset, and that `restart_pc` moves only on accepted words. The properties that compare one cycle with the previous cycle also assume that reset lasts at least one clock with `in_valid` low, so that no earlier word reaches back into the first checked cycle. The bench holds `in_valid` low during reset and for its first cycle out of reset. It drives every input on the falling edge from tasks, so that no input is undefined at a rising edge. It uses only the opcodes 4'hF, 4'hE and a few ordinary values.

// File: rtl/pfx_imm_acc.sv
module pfx_imm_acc #(
  parameter int PC_W     = 32,
  parameter int DATA_W   = 32,
  parameter int INSN_W   = 16,
  parameter int PAY_W    = 12,
  parameter int PFX_CODE = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] in_insn,
  input  logic [PC_W-1:0]   in_pc,
  input  logic              irq_req,
  output logic              use_imm,
  output logic [DATA_W-1:0] imm_out,
  output logic              nop_out,
  output logic [PC_W-1:0]   restart_pc
);
  localparam int OPC_W = INSN_W - PAY_W;

  logic [DATA_W-1:0] acc_q;
  logic              pend_q;
  logic [PC_W-1:0]   start_q;
  logic [PC_W-1:0]   rst_pc_q;

  logic is_pfx, take_irq, pfx_go, consume;

  assign is_pfx   = in_insn[INSN_W-1 -: OPC_W] == OPC_W'(PFX_CODE);
  assign take_irq = in_valid & irq_req;
  assign pfx_go   = in_valid & is_pfx & ~irq_req;
  assign consume  = in_valid & ~is_pfx & ~irq_req;

  assign nop_out    = in_valid & (is_pfx | irq_req);
  assign use_imm    = consume & pend_q;
  assign imm_out    = use_imm ? acc_q : '0;
  assign restart_pc = rst_pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      pend_q   <= 1'b0;
      start_q  <= '0;
      rst_pc_q <= '0;
    end else if (in_valid) begin
      rst_pc_q <= pend_q ? start_q : in_pc;
      if (take_irq || consume) begin
        acc_q  <= '0;
        pend_q <= 1'b0;
      end else if (pfx_go) begin
        acc_q  <= (acc_q << PAY_W) | DATA_W'(in_insn[PAY_W-1:0]);
        pend_q <= 1'b1;
        if (!pend_q) start_q <= in_pc;
      end
    end
  end
endmodule

// File: rtl/pfx_imm_acc_chk.sv
module pfx_imm_acc_chk #(
  parameter int PC_W     = 32,
  parameter int DATA_W   = 32,
  parameter int INSN_W   = 16,
  parameter int PAY_W    = 12,
  parameter int PFX_CODE = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [INSN_W-1:0] in_insn,
  input logic              irq_req,
  input logic              use_imm,
  input logic [DATA_W-1:0] imm_out,
  input logic              nop_out,
  input logic [PC_W-1:0]   restart_pc
);
  localparam int OPC_W = INSN_W - PAY_W;
  logic pfx_w;
  assign pfx_w = in_valid && !irq_req && (in_insn[INSN_W-1 -: OPC_W] == OPC_W'(PFX_CODE));

  assert_prefix_nop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_w |-> (nop_out && !use_imm));

  assert_imm_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    use_imm |=> !use_imm);

  assert_imm_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !use_imm |-> (imm_out == '0));

  assert_run_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pfx_w && $past(pfx_w)) |=> $stable(restart_pc));

  assert_irq_squash_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && irq_req) |-> (nop_out && !use_imm));

  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && irq_req) |=> !use_imm);

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (!nop_out && !use_imm));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(restart_pc));
endmodule

bind pfx_imm_acc pfx_imm_acc_chk #(
  .PC_W(PC_W), .DATA_W(DATA_W), .INSN_W(INSN_W), .PAY_W(PAY_W), .PFX_CODE(PFX_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
  .irq_req(irq_req), .use_imm(use_imm), .imm_out(imm_out),
  .nop_out(nop_out), .restart_pc(restart_pc)
);

// File: tb/sim_pfx_imm_acc.sv
`timescale 1ns/1ps
module sim_pfx_imm_acc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_insn = '0;
  logic [31:0] in_pc = '0;
  logic        irq_req = 1'b0;
  logic        use_imm, nop_out;
  logic [31:0] imm_out, restart_pc;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic        o_use, o_nop;
  logic [31:0] o_imm, o_rpc;

  always #5 clk = ~clk;

  pfx_imm_acc u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
    .in_pc(in_pc), .irq_req(irq_req), .use_imm(use_imm), .imm_out(imm_out),
    .nop_out(nop_out), .restart_pc(restart_pc)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input bit v, input logic [15:0] w, input logic [31:0] pc, input bit irq);
    @(negedge clk);
    in_valid = v; in_insn = w; in_pc = pc; irq_req = irq;
    #1;
    o_use = use_imm; o_nop = nop_out; o_imm = imm_out;
    @(posedge clk); #1;
    o_rpc = restart_pc;
    in_valid = 1'b0; irq_req = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk(restart_pc == 32'h0, "R9 restart after reset", restart_pc, 32'h0);
    chk(!use_imm && !nop_out && imm_out == 0, "R8 idle outputs at reset", {30'h0, use_imm, nop_out}, 32'h0);
  endtask

  task automatic t_plain();
    issue(1, 16'h1234, 32'h100, 0);
    chk(!o_use && !o_nop && o_imm == 0, "R4 plain word", {30'h0, o_use, o_nop}, 32'h0);
    chk(o_rpc == 32'h100, "R5 restart own pc", o_rpc, 32'h100);
    issue(1, 16'hEFFF, 32'h102, 0);
    chk(!o_nop && !o_use, "R1 opcode E not prefix", {31'h0, o_nop}, 32'h0);
  endtask

  task automatic t_single();
    issue(1, 16'hFABC, 32'h200, 0);
    chk(o_nop && !o_use, "R1 prefix is nop", {30'h0, o_nop, o_use}, 32'h2);
    chk(o_rpc == 32'h200, "R5 restart first prefix", o_rpc, 32'h200);
    issue(1, 16'h3012, 32'h202, 0);
    chk(o_use, "R3 consumer selects imm", {31'h0, o_use}, 32'h1);
    chk(o_imm == 32'hABC, "R2 single payload", o_imm, 32'hABC);
    chk(o_rpc == 32'h200, "R5 consumer restarts at run", o_rpc, 32'h200);
    issue(1, 16'h3012, 32'h204, 0);
    chk(!o_use && o_imm == 0, "R3 constant cleared", {31'h0, o_use}, 32'h0);
    chk(o_rpc == 32'h204, "R5 restart back to own pc", o_rpc, 32'h204);
  endtask

  task automatic t_triple();
    issue(1, 16'hF123, 32'h300, 0);
    issue(1, 16'hF456, 32'h302, 0);
    chk(o_rpc == 32'h300, "R6 second prefix holds", o_rpc, 32'h300);
    issue(1, 16'hF789, 32'h304, 0);
    chk(o_rpc == 32'h300, "R6 third prefix holds", o_rpc, 32'h300);
    issue(1, 16'h5000, 32'h306, 0);
    chk(o_imm == 32'h23456789, "R2 three payloads", o_imm, 32'h23456789);
  endtask

  task automatic t_wrap();
    issue(1, 16'hF111, 32'h340, 0);
    issue(1, 16'hF222, 32'h342, 0);
    issue(1, 16'hF333, 32'h344, 0);
    issue(1, 16'hF444, 32'h346, 0);
    issue(1, 16'h5000, 32'h348, 0);
    chk(o_imm == 32'h22333444, "R2 four payloads truncated", o_imm, 32'h22333444);
  endtask

  task automatic t_zero();
    issue(1, 16'hF000, 32'h800, 0);
    issue(1, 16'h2000, 32'h802, 0);
    chk(o_use && o_imm == 0, "R3 zero payload still selects", {31'h0, o_use}, 32'h1);
  endtask

  task automatic t_gap();
    issue(1, 16'hF00A, 32'h400, 0);
    issue(0, 16'h3333, 32'h999, 1);
    chk(!o_use && !o_nop && o_imm == 0, "R8 invalid cycle idle", {30'h0, o_use, o_nop}, 32'h0);
    chk(o_rpc == 32'h400, "R8 invalid irq keeps restart", o_rpc, 32'h400);
    issue(1, 16'h3000, 32'h402, 0);
    chk(o_use && o_imm == 32'hA, "R8 run survives invalid irq", o_imm, 32'hA);
  endtask

  task automatic t_irq();
    issue(1, 16'hF555, 32'h500, 0);
    issue(1, 16'hF666, 32'h502, 0);
    issue(1, 16'h4000, 32'h504, 1);
    chk(o_nop && !o_use, "R7 interrupted word squashed", {30'h0, o_nop, o_use}, 32'h2);
    chk(o_rpc == 32'h500, "R7 restart at run start", o_rpc, 32'h500);
    issue(1, 16'h4000, 32'h600, 0);
    chk(!o_use && o_imm == 0, "R7 run dropped", o_imm, 32'h0);
    chk(o_rpc == 32'h600, "R5 own pc after irq", o_rpc, 32'h600);
    issue(1, 16'h4000, 32'h700, 1);
    chk(o_rpc == 32'h700 && o_nop, "R7 irq on plain word", o_rpc, 32'h700);
    issue(1, 16'hF777, 32'h710, 1);
    issue(1, 16'h4000, 32'h712, 0);
    chk(!o_use, "R7 prefix under irq not kept", {31'h0, o_use}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk);
    t_reset();
    t_plain();
    t_single();
    t_triple();
    t_wrap();
    t_zero();
    t_gap();
    t_irq();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule